// File: doc/BRIEF.md
# Pipelined Eight-Point Hadamard Transform Stream Engine

This block is a streaming co-processor for a video encoder. It computes the eight-point one-dimensional Walsh-Hadamard transform of signed 16-bit samples. It also computes a sum-of-absolute-transformed-differences (SATD) cost for each vector. A processor pushes samples one 32-bit word at a time over a valid/ready input stream. The block gathers eight words into a vector and launches the vector as one unit into a butterfly datapath. That datapath has three add/subtract layers, with pair spacing 1, 2 and 4, and a register bank after each layer. Each layer widens the data by one bit, so the coefficients are 19-bit signed values.

Results go back over a matching valid/ready output stream as a frame of nine words. The first eight words are the coefficients in natural Hadamard index order, each sign-extended to 32 bits. The ninth word is the SATD cost. When the sink withdraws ready, every stage of the block freezes and the input stream is refused. No vector is lost or reordered. When the source keeps vectors coming and the sink stays ready, frames leave back to back with no idle cycle between them.

Top module: `hadamard_stream_pipe`

## Requirements
- R1: While reset is high, and after it is released, m_valid is low until a vector has been processed. With the pipeline empty and m_ready high, s_ready is high.
- R2: Eight accepted input words form one vector, and the first accepted word is element 0. Only bits [15:0] of a word are used, read as a two's-complement sample. Bits [31:16] have no effect on any output.
- R3: Output words 0 to 7 of a frame are y[k] = sum over j of (-1)^popcount(k AND j) * x[j], for k = 0 to 7 in that order. Each is a 19-bit signed value sign-extended to 32 bits, and full-scale inputs give exact results.
- R4: Output word 8 of a frame is floor((|y[0]| + ... + |y[7]|) / 2), zero-extended to 32 bits. An all -32768 vector gives 131072.
- R5: The pipeline starts empty and m_ready stays high. Then m_valid first goes high on the fourth rising edge after the edge that accepts the eighth input word.
- R6: While m_ready is low, s_ready is low, and m_valid and m_data hold their values.
- R7: Frames come out in the order their vectors were accepted, and none is lost. With inputs always offered and m_ready always high, m_valid stays high from the first word of the first frame to the last word of the last frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input word offered |
| s_ready | output | 1 | Input word can be accepted |
| s_data | input | 32 | Input word, sample in bits [15:0] |
| m_valid | output | 1 | Output word offered |
| m_ready | input | 1 | Sink accepts the output word |
| m_data | output | 32 | Coefficient or SATD cost word |

## Verification
The bench targets full-scale vectors: all +32767, all -32768 and alternating extremes. A layer that lost its carry bit would wrap the DC coefficient or the odd-index coefficients, and a wrong absolute value of the most negative coefficient would spoil the cost word. Words with junk in the upper half must produce the same frames as clean words; a gather stage that used the wrong bits would show at once. The bench holds the sink off while a frame is leaving and offers input at the same time. A stall that leaked would advance the data or accept the word. A long burst with the sink always ready exposes any bubble at the frame boundary, and a one-shot vector from idle pins the latency to four edges.

// File: rtl/wht_pkg.sv
package wht_pkg;

   // State of the word-serial output stage.
   typedef enum logic [1:0] {
      EM_IDLE = 2'd0,
      EM_COEF = 2'd1,
      EM_COST = 2'd2
   } emit_state_e;

   localparam int WHT_LOG2N_DEF  = 3;
   localparam int WHT_SAMPLE_DEF = 16;
   localparam int WHT_WORD_DEF   = 32;

endpackage

// File: rtl/wht_gather.sv
module wht_gather #(
   parameter int NPT      = 8,
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 19
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    allow,
   input  logic                    take,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [SAMPLE_W-1:0]     in_sample,
   output logic                    vec_valid,
   output logic [NPT*SLOT_W-1:0]   vec_data
);
   localparam int CNT_W = $clog2(NPT);

   logic [CNT_W-1:0] cnt_q;
   logic             full_q;
   logic             accept;
   logic             last_word;
   logic [SLOT_W-1:0] ext_sample;

   assign in_ready   = allow && (!full_q || take);
   assign accept     = in_valid && in_ready;
   assign last_word  = (cnt_q == CNT_W'(NPT - 1));
   assign vec_valid  = full_q;
   assign ext_sample = SLOT_W'($signed(in_sample));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         full_q <= 1'b0;
      end else begin
         if (accept) begin
            cnt_q <= last_word ? '0 : cnt_q + CNT_W'(1);
         end
         if (accept && last_word) begin
            full_q <= 1'b1;
         end else if (take) begin
            full_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         vec_data[int'(cnt_q)*SLOT_W +: SLOT_W] <= ext_sample;
      end
   end

endmodule

// File: rtl/wht_bfly_stage.sv
module wht_bfly_stage #(
   parameter int NPT    = 8,
   parameter int SPAN   = 1,
   parameter int IN_W   = 16,
   parameter int SLOT_W = 19
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  en,
   input  logic                  in_valid,
   input  logic [NPT*SLOT_W-1:0] in_vec,
   output logic                  out_valid,
   output logic [NPT*SLOT_W-1:0] out_vec
);
   localparam int OUT_W = IN_W + 1;

   logic [NPT*SLOT_W-1:0] nxt;
   logic signed [OUT_W-1:0] lo_v;
   logic signed [OUT_W-1:0] hi_v;
   logic signed [OUT_W-1:0] sum_v;
   logic signed [OUT_W-1:0] dif_v;
   logic unused_top;

   // Each pair (i, i+SPAN) with bit SPAN of i clear forms one butterfly.
   always_comb begin
      nxt   = '0;
      lo_v  = '0;
      hi_v  = '0;
      sum_v = '0;
      dif_v = '0;
      for (int i = 0; i < NPT; i++) begin
         if ((i & SPAN) == 0) begin
            lo_v  = OUT_W'($signed(in_vec[i*SLOT_W +: IN_W]));
            hi_v  = OUT_W'($signed(in_vec[(i+SPAN)*SLOT_W +: IN_W]));
            sum_v = lo_v + hi_v;
            dif_v = lo_v - hi_v;
            nxt[i*SLOT_W +: SLOT_W]        = SLOT_W'(sum_v);
            nxt[(i+SPAN)*SLOT_W +: SLOT_W] = SLOT_W'(dif_v);
         end
      end
   end

   // Bits above IN_W are only sign copies at this layer.
   always_comb begin
      unused_top = 1'b0;
      for (int i = 0; i < NPT; i++) begin
         unused_top = unused_top ^ (^in_vec[i*SLOT_W+IN_W +: (SLOT_W-IN_W)]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else if (en) begin
         out_valid <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (en && in_valid) begin
         out_vec <= nxt;
      end
   end

endmodule

// File: rtl/wht_abs_sum.sv
module wht_abs_sum #(
   parameter int NPT    = 8,
   parameter int COEF_W = 19,
   parameter int SUM_W  = 22
) (
   input  logic [NPT*COEF_W-1:0] vec,
   output logic [SUM_W-2:0]      cost
);
   logic [SUM_W-1:0]  acc;
   logic [COEF_W-1:0] coef;
   logic [COEF_W-1:0] mag;
   logic              unused_lsb;

   // The magnitude is read as unsigned, so the most negative code maps to 2^(COEF_W-1).
   always_comb begin
      acc  = '0;
      coef = '0;
      mag  = '0;
      for (int i = 0; i < NPT; i++) begin
         coef = vec[i*COEF_W +: COEF_W];
         mag  = coef[COEF_W-1] ? (~coef + COEF_W'(1)) : coef;
         acc  = acc + SUM_W'(mag);
      end
   end

   assign cost       = acc[SUM_W-1:1];
   assign unused_lsb = acc[0];

endmodule

// File: rtl/wht_emit.sv
module wht_emit
   import wht_pkg::*;
#(
   parameter int NPT    = 8,
   parameter int COEF_W = 19,
   parameter int COST_W = 21,
   parameter int WORD_W = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load,
   input  logic [NPT*COEF_W-1:0] in_vec,
   input  logic [COST_W-1:0]     in_cost,
   output logic                  can_load,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [WORD_W-1:0]     out_data
);
   localparam int IDX_W = $clog2(NPT);

   emit_state_e           st_q;
   logic [IDX_W-1:0]      idx_q;
   logic [NPT*COEF_W-1:0] vec_q;
   logic [COST_W-1:0]     cost_q;
   logic [WORD_W-1:0]     coef_word;
   logic [WORD_W-1:0]     cost_word;

   assign can_load  = (st_q == EM_IDLE) || ((st_q == EM_COST) && out_ready);
   assign out_valid = (st_q != EM_IDLE);
   assign coef_word = WORD_W'($signed(vec_q[int'(idx_q)*COEF_W +: COEF_W]));
   assign cost_word = WORD_W'(cost_q);
   assign out_data  = (st_q == EM_COST) ? cost_word : coef_word;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= EM_IDLE;
         idx_q <= '0;
      end else begin
         case (st_q)
            EM_IDLE: begin
               if (load) begin
                  st_q  <= EM_COEF;
                  idx_q <= '0;
               end
            end
            EM_COEF: begin
               if (out_ready) begin
                  if (idx_q == IDX_W'(NPT - 1)) begin
                     st_q <= EM_COST;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            EM_COST: begin
               if (out_ready) begin
                  st_q  <= load ? EM_COEF : EM_IDLE;
                  idx_q <= '0;
               end
            end
            default: begin
               st_q  <= EM_IDLE;
               idx_q <= '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (load) begin
         vec_q  <= in_vec;
         cost_q <= in_cost;
      end
   end

endmodule

// File: rtl/hadamard_stream_pipe.sv
module hadamard_stream_pipe
   import wht_pkg::*;
#(
   parameter int LOG2N    = WHT_LOG2N_DEF,
   parameter int SAMPLE_W = WHT_SAMPLE_DEF,
   parameter int WORD_W   = WHT_WORD_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [WORD_W-1:0] s_data,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [WORD_W-1:0] m_data
);
   localparam int NPT    = 1 << LOG2N;
   localparam int COEF_W = SAMPLE_W + LOG2N;
   localparam int SUM_W  = COEF_W + LOG2N;
   localparam int COST_W = SUM_W - 1;

   if (LOG2N < 1 || LOG2N > 6) begin : g_bad_points
      $error("LOG2N must lie in 1..6");
   end
   if (SAMPLE_W < 2) begin : g_bad_sample
      $error("SAMPLE_W must be at least 2");
   end
   if (WORD_W <= SAMPLE_W || WORD_W < COST_W) begin : g_bad_word
      $error("WORD_W too narrow for samples or cost");
   end

   logic [NPT*COEF_W-1:0] stage_vec [LOG2N+1];
   logic                  stage_vld [LOG2N+1];
   logic                  pipe_en;
   logic                  emit_can;
   logic                  emit_load;
   logic [COST_W-1:0]     cost;
   logic                  unused_hi;

   assign unused_hi = ^s_data[WORD_W-1:SAMPLE_W];

   // One shared advance: the tail moves when the sink is ready and the emitter has room.
   assign pipe_en   = m_ready && (!stage_vld[LOG2N] || emit_can);
   assign emit_load = pipe_en && stage_vld[LOG2N];

   wht_gather #(
      .NPT      (NPT),
      .SAMPLE_W (SAMPLE_W),
      .SLOT_W   (COEF_W)
   ) u_gather (
      .clk       (clk),
      .rst       (rst),
      .allow     (m_ready),
      .take      (pipe_en),
      .in_valid  (s_valid),
      .in_ready  (s_ready),
      .in_sample (s_data[SAMPLE_W-1:0]),
      .vec_valid (stage_vld[0]),
      .vec_data  (stage_vec[0])
   );

   for (genvar g = 0; g < LOG2N; g++) begin : g_layer
      wht_bfly_stage #(
         .NPT    (NPT),
         .SPAN   (1 << g),
         .IN_W   (SAMPLE_W + g),
         .SLOT_W (COEF_W)
      ) u_stage (
         .clk       (clk),
         .rst       (rst),
         .en        (pipe_en),
         .in_valid  (stage_vld[g]),
         .in_vec    (stage_vec[g]),
         .out_valid (stage_vld[g+1]),
         .out_vec   (stage_vec[g+1])
      );
   end

   wht_abs_sum #(
      .NPT    (NPT),
      .COEF_W (COEF_W),
      .SUM_W  (SUM_W)
   ) u_abs_sum (
      .vec  (stage_vec[LOG2N]),
      .cost (cost)
   );

   wht_emit #(
      .NPT    (NPT),
      .COEF_W (COEF_W),
      .COST_W (COST_W),
      .WORD_W (WORD_W)
   ) u_emit (
      .clk       (clk),
      .rst       (rst),
      .load      (emit_load),
      .in_vec    (stage_vec[LOG2N]),
      .in_cost   (cost),
      .can_load  (emit_can),
      .out_valid (m_valid),
      .out_ready (m_ready),
      .out_data  (m_data)
   );

endmodule

// File: rtl/wht_stream_checker.sv
module wht_stream_checker #(
   parameter int NPT    = 8,
   parameter int COEF_W = 19,
   parameter int COST_W = 21,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              s_ready,
   input logic              m_valid,
   input logic              m_ready,
   input logic [WORD_W-1:0] m_data
);
   localparam int CW = $clog2(NPT + 1);

   logic [CW-1:0] word_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         word_cnt <= '0;
      end else if (m_valid && m_ready) begin
         word_cnt <= (word_cnt == CW'(NPT)) ? '0 : word_cnt + CW'(1);
      end
   end

   AST_IDLE_IN_RESET: assert property (@(posedge clk) rst |=> !m_valid); // R1

   AST_SRC_STALL: assert property (@(posedge clk) disable iff (rst)
      !m_ready |-> !s_ready); // R6

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R6

   AST_COEF_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
      (m_valid && word_cnt < CW'(NPT)) |->
      ((&m_data[WORD_W-1:COEF_W-1]) || !(|m_data[WORD_W-1:COEF_W-1]))); // R3

   AST_COST_RANGE: assert property (@(posedge clk) disable iff (rst)
      (m_valid && word_cnt == CW'(NPT)) |-> ((m_data >> COST_W) == '0)); // R4

endmodule

bind hadamard_stream_pipe wht_stream_checker #(
   .NPT    (NPT),
   .COEF_W (COEF_W),
   .COST_W (COST_W),
   .WORD_W (WORD_W)
) u_checker (
   .clk     (clk),
   .rst     (rst),
   .s_ready (s_ready),
   .m_valid (m_valid),
   .m_ready (m_ready),
   .m_data  (m_data)
);

// File: tb/hadamard_stream_pipe_tb_top.sv
module hadamard_stream_pipe_tb_top;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic [31:0] s_data = '0;
   logic        m_valid;
   logic        m_ready = 1'b1;
   logic [31:0] m_data;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int ready_mode = 0;
   int last_in_cyc = 0;
   bit lat_armed = 0;
   bit gap_arm = 0;
   bit gap_watch = 0;
   int gap_cnt = 0;
   bit done = 0;

   int          in_buf[$];
   logic [31:0] exp_q[$];
   int          pos_q[$];

   always #5 clk = ~clk;

   hadamard_stream_pipe dut_i (
      .clk     (clk),
      .rst     (rst),
      .s_valid (s_valid),
      .s_ready (s_ready),
      .s_data  (s_data),
      .m_valid (m_valid),
      .m_ready (m_ready),
      .m_data  (m_data)
   );

   always @(posedge clk) cyc++;

   always @(posedge clk) begin
      #2;
      case (ready_mode)
         0:       m_ready = 1'b1;
         1:       m_ready = 1'b0;
         default: m_ready = (($urandom % 4) != 0);
      endcase
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Reference: direct matrix product with the (-1)^popcount(k&j) sign pattern.
   task automatic build_expect();
      longint total = 0;
      for (int k = 0; k < N; k++) begin
         int c = 0;
         for (int j = 0; j < N; j++) begin
            if (($countones(k & j) % 2) == 1) c -= in_buf[j];
            else                              c += in_buf[j];
         end
         total += (c < 0) ? -c : c;
         exp_q.push_back(32'(c));
         pos_q.push_back(k);
      end
      exp_q.push_back(32'(total / 2));
      pos_q.push_back(N);
   endtask

   // Monitor: every clock, away from the rising edge.
   always @(negedge clk) begin
      if (!rst) begin
         if (s_valid && s_ready) begin
            in_buf.push_back(int'($signed(s_data[15:0])));
            if (in_buf.size() == N) begin
               build_expect();
               in_buf.delete();
               last_in_cyc = cyc;
            end
         end
         if (m_valid && m_ready) begin
            if (exp_q.size() == 0) begin
               chk(0, "R7", "word with no vector pending", longint'(m_data), 0);
            end else begin
               logic [31:0] e;
               int p;
               e = exp_q.pop_front();
               p = pos_q.pop_front();
               if (p == N) chk(m_data == e, "R4", "cost word", longint'(m_data), longint'(e));
               else        chk(m_data == e, "R3", $sformatf("coef %0d", p),
                               longint'($signed(m_data)), longint'($signed(e)));
            end
         end
         if (lat_armed && m_valid) begin
            // Edge accepting word 8 sets cyc to last_in_cyc+1; fourth edge after it gives +5.
            chk(cyc - last_in_cyc == 5, "R5", "latency", cyc - last_in_cyc, 5);
            lat_armed = 0;
         end
         if (gap_arm && m_valid) gap_watch = 1;
         if (gap_watch && !m_valid && exp_q.size() != 0) gap_cnt++;
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         errors++;
         checks++;
         $display("FAIL R7 watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic send_vec(input int vv[N], input bit junk, input bit gaps);
      for (int k = 0; k < N; k++) begin
         bit ok;
         if (gaps) begin
            while (($urandom % 3) == 0) begin
               s_valid = 1'b0;
               @(posedge clk); #1;
            end
         end
         s_valid = 1'b1;
         s_data  = junk ? {16'($urandom), 16'(vv[k])} : 32'(vv[k]);
         do begin
            @(negedge clk);
            ok = s_ready;
            @(posedge clk); #1;
         end while (!ok);
      end
      s_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || in_buf.size() != 0) @(posedge clk);
      repeat (2) @(posedge clk);
      #1;
   endtask

   initial begin
      int v[N];
      logic [31:0] held;

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(m_valid == 0, "R1", "valid during reset", m_valid, 0);
      @(posedge clk); #1 rst = 1'b0;
      @(negedge clk);
      chk(m_valid == 0, "R1", "valid after reset", m_valid, 0);
      chk(s_ready == 1, "R1", "ready when idle", s_ready, 1);
      @(posedge clk); #1;

      // R5 and R3: one vector from idle
      lat_armed = 1;
      v = '{1, 2, 3, 4, 5, 6, 7, 8};
      send_vec(v, 0, 0);
      drain();

      // R3/R4 full-scale vectors
      v = '{32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767};
      send_vec(v, 0, 0);
      v = '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768};
      send_vec(v, 0, 0);
      v = '{32767, -32768, 32767, -32768, -32768, 32767, -32768, 32767};
      send_vec(v, 0, 0);
      drain();

      // R2: junk in upper half must not matter
      v = '{-1, 100, -200, 300, 0, -32768, 32767, 7};
      send_vec(v, 1, 0);
      send_vec(v, 1, 1);
      drain();

      // R6: stall while a frame is leaving, with input offered
      v = '{10, -20, 30, -40, 50, -60, 70, -80};
      send_vec(v, 0, 0);
      @(negedge clk);
      while (!m_valid) @(negedge clk);
      @(posedge clk); #1 ready_mode = 1;
      s_valid = 1'b1;
      s_data  = 32'h0000_1234;
      @(negedge clk);
      held = m_data;
      for (int t = 0; t < 5; t++) begin
         chk(m_valid == 1, "R6", "valid held", m_valid, 1);
         chk(m_data == held, "R6", "data held", longint'(m_data), longint'(held));
         chk(s_ready == 0, "R6", "input refused", s_ready, 0);
         @(negedge clk);
      end
      @(posedge clk); #1 s_valid = 1'b0;
      ready_mode = 0;
      drain();

      // R3/R4 random traffic with random backpressure and source gaps
      ready_mode = 2;
      for (int n = 0; n < 30; n++) begin
         for (int k = 0; k < N; k++) begin
            case ($urandom % 5)
               0:       v[k] = 32767;
               1:       v[k] = -32768;
               default: v[k] = int'($urandom_range(65535)) - 32768;
            endcase
         end
         send_vec(v, n[0], 1);
      end
      @(posedge clk); #1 ready_mode = 0;
      drain();

      // R7: continuous burst, sink always ready, no bubble between frames
      gap_cnt = 0;
      gap_arm = 1;
      for (int n = 0; n < 6; n++) begin
         for (int k = 0; k < N; k++) v[k] = int'($urandom_range(65535)) - 32768;
         send_vec(v, 0, 0);
      end
      drain();
      gap_arm = 0;
      gap_watch = 0;
      chk(gap_cnt == 0, "R7", "idle cycles inside burst", gap_cnt, 0);
      chk(exp_q.size() == 0, "R7", "frames missing", exp_q.size(), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule